// File: doc/BRIEF.md
# Programmable 24-Line Parallel Port Group (Basic Mode)

This block is a single group of 24 general-purpose parallel I/O lines behind a byte-wide register interface. The lines form three byte-wide ports. The first two are whole bytes. The third is split into an upper nibble and a lower nibble, and each nibble has its own direction. One configuration word chooses input or output for each of the four sections. A section set as output drives the value last written to it. A section set as input lets software read the present state of its pins.

Software reaches the block through four byte registers. The write channel and the read channel are separate, so a read and a write can be issued in the same cycle. Read data is registered and returns one cycle after the request. After reset every line is undriven and set as input, so the lines can be read with no setup. Only plain, unstrobed input and output are provided.

Top module: `pio_group`

## Requirements
- R1: After reset, pin_oe and pin_out are all zero, every section is an input, and reading the configuration register returns 0x9B.
- R2: Register addresses are fixed: 0 is port A, 1 is port B, 2 is port C and 3 is the configuration word. A read of address 3 returns the last accepted configuration word.
- R3: In the configuration word, bit 4 sets port A, bit 1 sets port B, bit 3 sets the C upper nibble and bit 0 sets the C lower nibble, and 1 means input. Pin mapping: A is pins[7:0], B is pins[15:8], C lower is pins[19:16], C upper is pins[23:20]. 0x80 makes every section an output and 0x9B makes every section an input.
- R4: A configuration write with bit 7 set clears every output latch to zero in the same cycle that the new directions take effect.
- R5: A configuration write with bit 7 clear is ignored. The configuration readback, pin_oe and pin_out are all unchanged.
- R6: An output section drives its latch on pin_out with pin_oe high. A read of it returns the latch, not the pins.
- R7: An input section returns its pin state when read. Pins are sampled into a register every cycle, so a read reflects pins that have been stable for two clock edges.
- R8: A data write to an input section leaves that section undriven (pin_oe and pin_out low), and reads still return the pins.
- R9: A port C write sets both nibble latches from the byte. A port C read takes each nibble from its latch or from its pins, according to that nibble's own direction.
- R10: rd_valid rises exactly one cycle after rd_en. A read issued in the same cycle as a write returns the value from before that write.
- R11: Configuration bits 6, 5 and 2 are stored and read back. They do not change the basic input/output behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | PORT_W | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 2 | Read register address |
| rd_data | output | PORT_W | Registered read data |
| rd_valid | output | 1 | rd_data is valid |
| pin_in | input | 3*PORT_W | Pin states seen from outside |
| pin_out | output | 3*PORT_W | Output pin values |
| pin_oe | output | 3*PORT_W | Per-pin output enable |

## Verification
A read and a write can land in the same cycle because the two channels are separate. The case that matters is a read of a port or of the configuration word while that same register is being written. The bench issues both in one cycle, on a data port and on the configuration register, and expects the value from before the write. The next read must then return the new value. A model snapshot taken before the write is applied gives the expected value, and a scoreboard queue matches it against the registered read data as it arrives.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int NSECT = 4;

    localparam int CFG_ACT = 7;
    localparam int CFG_A   = 4;
    localparam int CFG_CU  = 3;
    localparam int CFG_B   = 1;
    localparam int CFG_CL  = 0;

    localparam logic [7:0] CFG_RESET = 8'h9B;

    localparam logic [1:0] REG_PA  = 2'd0;
    localparam logic [1:0] REG_PB  = 2'd1;
    localparam logic [1:0] REG_PC  = 2'd2;
    localparam logic [1:0] REG_CFG = 2'd3;

    typedef struct packed {
        logic cu_in;
        logic cl_in;
        logic b_in;
        logic a_in;
    } dir_t;

    function automatic dir_t cfg_to_dir(input logic [7:0] w);
        dir_t d;
        d.a_in  = w[CFG_A];
        d.b_in  = w[CFG_B];
        d.cl_in = w[CFG_CL];
        d.cu_in = w[CFG_CU];
        return d;
    endfunction

    // section index: 0 = A, 1 = B, 2 = C lower, 3 = C upper
    function automatic logic sect_input(input dir_t d, input int s);
        case (s)
            0:       return d.a_in;
            1:       return d.b_in;
            2:       return d.cl_in;
            default: return d.cu_in;
        endcase
    endfunction

    function automatic int sect_width(input int s, input int pw);
        return (s < 2) ? pw : pw / 2;
    endfunction

    function automatic int sect_base(input int s, input int pw);
        case (s)
            0:       return 0;
            1:       return pw;
            2:       return 2 * pw;
            default: return 2 * pw + pw / 2;
        endcase
    endfunction

    function automatic int sect_byte_lo(input int s, input int pw);
        return (s == 3) ? pw / 2 : 0;
    endfunction

    function automatic logic [1:0] sect_reg(input int s);
        case (s)
            0:       return REG_PA;
            1:       return REG_PB;
            default: return REG_PC;
        endcase
    endfunction

endpackage

// File: rtl/pio_cfg_reg.sv
module pio_cfg_reg
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_cfg,
    input  logic [7:0] wr_word,
    output logic [7:0] cfg_q,
    output dir_t       dir,
    output logic       clear_all
);

    logic accept;

    assign accept    = wr_cfg && wr_word[CFG_ACT];
    assign clear_all = accept;
    assign dir       = cfg_to_dir(cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (accept) begin
            cfg_q <= wr_word;
        end
    end

    a_r5_inactive_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && !wr_word[CFG_ACT]) |=> $stable(cfg_q));

    a_r2_cfg_stored: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && wr_word[CFG_ACT]) |=> (cfg_q == $past(wr_word)));

endmodule

// File: rtl/pio_sect.sv
module pio_sect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         clr,
    input  logic [W-1:0] load_val,
    input  logic         is_input,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_val
);

    logic [W-1:0] latch_q;
    logic [W-1:0] samp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (clr) begin
            latch_q <= '0;
        end else if (load) begin
            latch_q <= load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= '0;
        end else begin
            samp_q <= pin_in;
        end
    end

    assign pin_oe  = {W{~is_input}};
    assign pin_out = latch_q & pin_oe;
    assign rd_val  = is_input ? samp_q : latch_q;

    a_r4_clr_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (latch_q == '0));

    a_r6_latch_load: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (latch_q == $past(load_val)));

    a_r7_sample: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst)) |-> (samp_q == $past(pin_in)));

endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
    import pio_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic [1:0]          sel,
    input  logic [3*PORT_W-1:0] sect_rd,
    input  logic [7:0]          cfg_q,
    output logic [PORT_W-1:0]   rd_byte
);

    always_comb begin
        rd_byte = '0;
        case (sel)
            REG_PA:  rd_byte = sect_rd[0 +: PORT_W];
            REG_PB:  rd_byte = sect_rd[PORT_W +: PORT_W];
            REG_PC:  rd_byte = sect_rd[2*PORT_W +: PORT_W];
            default: rd_byte[7:0] = cfg_q;
        endcase
    end

endmodule

// File: rtl/pio_group.sv
module pio_group
    import pio_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [PORT_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [1:0]          rd_addr,
    output logic [PORT_W-1:0]   rd_data,
    output logic                rd_valid,
    input  logic [3*PORT_W-1:0] pin_in,
    output logic [3*PORT_W-1:0] pin_out,
    output logic [3*PORT_W-1:0] pin_oe
);

    localparam int PINS = 3 * PORT_W;

    logic            wr_cfg;
    logic [7:0]      cfg_q;
    dir_t            dir;
    logic            clear_all;
    logic [PINS-1:0] sect_rd;
    logic [PORT_W-1:0] rd_byte;

    assign wr_cfg = wr_en && (wr_addr == REG_CFG);

    pio_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_cfg    (wr_cfg),
        .wr_word   (wr_data[7:0]),
        .cfg_q     (cfg_q),
        .dir       (dir),
        .clear_all (clear_all)
    );

    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        localparam int SW   = sect_width(s, PORT_W);
        localparam int BASE = sect_base(s, PORT_W);
        localparam int LO   = sect_byte_lo(s, PORT_W);

        logic ld;
        logic in_mode;

        assign ld      = wr_en && (wr_addr == sect_reg(s));
        assign in_mode = sect_input(dir, s);

        pio_sect #(.W(SW)) u_sect (
            .clk      (clk),
            .rst      (rst),
            .load     (ld),
            .clr      (clear_all),
            .load_val (wr_data[LO +: SW]),
            .is_input (in_mode),
            .pin_in   (pin_in[BASE +: SW]),
            .pin_out  (pin_out[BASE +: SW]),
            .pin_oe   (pin_oe[BASE +: SW]),
            .rd_val   (sect_rd[BASE +: SW])
        );
    end

    pio_rd_mux #(.PORT_W(PORT_W)) u_mux (
        .sel     (rd_addr),
        .sect_rd (sect_rd),
        .cfg_q   (cfg_q),
        .rd_byte (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_byte;
            end
        end
    end

    a_r1_reset_undriven: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0));

    a_r10_rd_latency: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    a_r4_clear_out: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && wr_data[CFG_ACT]) |=> (pin_out == '0));

    a_r8_a_input_undriven: assert property (@(posedge clk) disable iff (rst)
        cfg_q[CFG_A] |-> (pin_oe[PORT_W-1:0] == '0));

endmodule

// File: tb/tb_pio_group.sv
module tb_pio_group;

    localparam int PW = 8;
    localparam int NP = 3 * PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [PW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_addr = '0;
    logic [PW-1:0] rd_data;
    logic          rd_valid;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    always #4 clk = ~clk;

    pio_group #(.PORT_W(PW)) dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0]    cfg_m = 8'h9B;
    logic [NP-1:0] latch_m = '0;
    logic [NP-1:0] pins_m = '0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    function automatic logic [NP-1:0] oe_m();
        return {{4{~cfg_m[3]}}, {4{~cfg_m[0]}}, {8{~cfg_m[1]}}, {8{~cfg_m[4]}}};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        logic [NP-1:0] mix;
        mix = (latch_m & oe_m()) | (pins_m & ~oe_m());
        case (a)
            2'd0:    return mix[7:0];
            2'd1:    return mix[15:8];
            2'd2:    return mix[23:16];
            default: return cfg_m;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle; entered and left at posedge+2
    task automatic bus(input logic we, input logic [1:0] wa, input logic [7:0] wd,
                       input logic re, input logic [1:0] ra, input string tag);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra;
        if (re) begin
            exp_q.push_back(exp_rd(ra));
            tag_q.push_back(tag);
        end
        if (we) begin
            if (wa == 2'd3) begin
                if (wd[7]) begin
                    cfg_m = wd;
                    latch_m = '0;
                end
            end else if (wa == 2'd0) latch_m[7:0] = wd;
            else if (wa == 2'd1) latch_m[15:8] = wd;
            else latch_m[23:16] = wd;
        end
        @(posedge clk); #2;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus(1'b1, a, d, 1'b0, 2'd0, "");
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        bus(1'b0, 2'd0, 8'h00, 1'b1, a, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        pins_m = v;
        pin_in = v;
        idle(2);
    endtask

    task automatic chk_pins(input string tag);
        idle(1);
        chk({tag, " oe"}, 32'(pin_oe), 32'(oe_m()));
        chk({tag, " out"}, 32'(pin_out), 32'(latch_m & oe_m()));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R10 unexpected read data actual=%h expected=none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, 32'(rd_data), 32'(e));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1 reset state
        chk("R1 reset oe", 32'(pin_oe), 32'h0);
        chk("R1 reset out", 32'(pin_out), 32'h0);
        rd(2'd3, "R1 R2 reset cfg readback");

        // R7 inputs read pins
        set_pins(24'hC3_5A_A5);
        rd(2'd0, "R7 read A pins");
        rd(2'd1, "R7 read B pins");
        rd(2'd2, "R7 read C pins");

        // R8 write to input section
        wr(2'd0, 8'h11);
        chk_pins("R8 A input write undriven");
        rd(2'd0, "R8 A still pins");

        // R3/R4 all outputs, latches cleared
        wr(2'd3, 8'h80);
        chk_pins("R3 R4 cfg 0x80");
        rd(2'd0, "R4 A cleared");

        // R6 outputs drive and read back latch
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'hC5);
        wr(2'd2, 8'h96);
        chk_pins("R6 drive");
        rd(2'd0, "R6 A latch");
        rd(2'd1, "R6 B latch");
        rd(2'd2, "R6 C latch");
        set_pins(24'h0F_F0_0F);
        rd(2'd1, "R6 B ignores pins");

        // R5 inactive config write
        wr(2'd3, 8'h0B);
        chk_pins("R5 ignored");
        rd(2'd3, "R5 cfg unchanged");

        // R9 split port C
        wr(2'd3, 8'h88);
        wr(2'd2, 8'hAB);
        chk_pins("R9 CU in CL out");
        rd(2'd2, "R9 C mixed 0x88");
        wr(2'd3, 8'h81);
        wr(2'd2, 8'h7E);
        chk_pins("R9 CU out CL in");
        rd(2'd2, "R9 C mixed 0x81");

        // R3 other patterns
        wr(2'd3, 8'h92);
        chk_pins("R3 cfg 0x92");
        wr(2'd3, 8'h8A);
        chk_pins("R3 cfg 0x8A");

        // R11 mode bits stored, no effect
        wr(2'd3, 8'hF6);
        rd(2'd3, "R11 cfg readback");
        wr(2'd2, 8'h5C);
        chk_pins("R11 mode bits ignored");
        rd(2'd2, "R11 C latch");
        rd(2'd0, "R11 A pins");

        // R10 same-cycle read and write
        wr(2'd3, 8'h80);
        wr(2'd0, 8'h42);
        bus(1'b1, 2'd0, 8'h99, 1'b1, 2'd0, "R10 same-cycle old A");
        rd(2'd0, "R10 new A");
        bus(1'b1, 2'd3, 8'h9B, 1'b1, 2'd3, "R10 same-cycle old cfg");
        rd(2'd3, "R10 new cfg");
        chk_pins("R3 cfg 0x9B");
        rd(2'd0, "R7 A pins after 0x9B");

        idle(3);
        chk("R10 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule